// File: doc/BRIEF.md
# Transactional Execution Cycle Profiler

This block is a per-core set of cycle counters for a processor that runs hardware memory transactions. Each clock cycle goes into exactly one bucket. The buckets are: stalled on a conflicting request, rolling back an abort, speculative work later thrown away, speculative work that committed, committing, ordinary non-transactional work, backing off before a retry, and waiting in a barrier.

The core sends one-cycle event pulses. The block keeps a free-running cycle stamp and the stamp at which the current interval opened. When an event closes an interval, the block adds the elapsed length to the matching counter. A transaction that aborts has its elapsed work booked as wasted when the abort starts. Work from a transaction that commits is booked as useful. In both cases the stall cycles already counted inside that attempt are subtracted, so no cycle is counted twice.

Software reads the counters through a one-cycle registered read port. A write to a clear address restarts the whole profile. The counters saturate and never wrap. An event that does not fit the current phase is ignored and sets a sticky error flag.

Top module: `txprof_top`

## Requirements
- R1: At any moment, the total-cycle counter (read address 0) equals the sum of the eight category counters plus the length of the interval still open. Every cycle after a clear is counted in exactly one category.
- R2: A conflict pulse after a request pulse adds (conflict cycle − request cycle) to the stall counter (address 1). A conflict pulse with no outstanding request is illegal.
- R3: An abort-start pulse adds (abort-start cycle − attempt begin cycle − stalls counted in that attempt) to the wasted counter (address 3). The following abort-done pulse adds (done − start) to the abort counter (address 2).
- R4: A retry pulse after abort-done adds (retry − abort-done) to the backoff counter (address 7) and opens a new transactional attempt at the retry cycle.
- R5: A commit-start pulse adds (commit-start − begin − stalls in the attempt) to the useful counter (address 4). The following commit-done pulse adds (done − start) to the commit counter (address 5).
- R6: A commit-done pulse that arrives inside a transaction with no commit-start adds zero to the commit counter. It books (done − begin − stalls) as useful work.
- R7: The non-transactional counter (address 6) receives (begin or barrier-enter cycle − cycle of the last commit-done, barrier-exit or clear+1). The barrier counter (address 8) receives (exit − enter).
- R8: At abort-done, the read-set and write-set size inputs are latched. They are readable at addresses 9 and 10.
- R9: An event that is not legal in the current phase (for example, abort-done outside an abort) changes no counter or phase. It sets a sticky error flag, visible on `err` and as bit 0 of address 11.
- R10: A cycle with more than one event pulse is ignored as a whole and sets the error flag.
- R11: Every counter saturates at its all-ones value instead of wrapping.
- R12: Reset, or a write of 1 on `wr_data` to address 15, zeroes every counter, the latched sizes and the error flag, and returns the profiler to the non-transactional phase. Read data appears on the clock edge after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_begin | input | 1 | Transaction begin pulse |
| ev_req | input | 1 | Memory request issued pulse |
| ev_conflict | input | 1 | Conflict detected pulse |
| ev_abort_start | input | 1 | Abort initiated pulse |
| ev_abort_done | input | 1 | Abort completed pulse |
| ev_retry | input | 1 | Transaction retry pulse |
| ev_commit_start | input | 1 | Commit initiated pulse |
| ev_commit_done | input | 1 | Commit completed pulse |
| ev_bar_enter | input | 1 | Barrier entered pulse |
| ev_bar_exit | input | 1 | Barrier left pulse |
| rs_size | input | SZ_W | Current read-set size |
| ws_size | input | SZ_W | Current write-set size |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 1 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| err | output | 1 | Sticky illegal-event flag |

## Verification
A wrong phase or a stale interval stamp does not show at the moment it occurs. It shows only when the next closing event books a length into a counter. Two cycles after that event, a read returns a value that differs from the bench's stamp arithmetic, and usually a second counter differs as well, because each cycle belongs to exactly one category. The partition identity checked against the total counter catches any lost or double-counted cycle at the first read after the sequence. A missing error flag shows on the `err` pin one cycle after the offending pulse.

// File: rtl/txprof_pkg.sv
package txprof_pkg;
  localparam int NEV = 10;
  localparam int EV_BEGIN  = 0;
  localparam int EV_REQ    = 1;
  localparam int EV_CONF   = 2;
  localparam int EV_ABST   = 3;
  localparam int EV_ABDN   = 4;
  localparam int EV_RETRY  = 5;
  localparam int EV_CMST   = 6;
  localparam int EV_CMDN   = 7;
  localparam int EV_BARIN  = 8;
  localparam int EV_BAROUT = 9;

  localparam int NCAT = 8;
  localparam int CW   = 3;
  typedef enum logic [CW-1:0] {
    CAT_STALL, CAT_ABORT, CAT_WASTED, CAT_USEFUL,
    CAT_COMMIT, CAT_NONTX, CAT_BACKOFF, CAT_BARRIER
  } cat_e;

  typedef enum logic [2:0] {
    S_IDLE, S_TXN, S_ABORT, S_BACKOFF, S_COMMIT, S_BARRIER
  } st_e;

  localparam int AW = 4;
  localparam logic [AW-1:0] A_TOTAL = 4'd0;
  localparam logic [AW-1:0] A_RSZ   = 4'd9;
  localparam logic [AW-1:0] A_WSZ   = 4'd10;
  localparam logic [AW-1:0] A_ERR   = 4'd11;
  localparam logic [AW-1:0] A_CLR   = 4'd15;
endpackage

// File: rtl/txprof_fsm.sv
module txprof_fsm
  import txprof_pkg::*;
#(
  parameter int TS_W = 32,
  parameter int SZ_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [NEV-1:0]  ev,
  input  logic [SZ_W-1:0] rs_size,
  input  logic [SZ_W-1:0] ws_size,
  output logic            add_vld,
  output cat_e            add_cat,
  output logic [TS_W-1:0] add_amt,
  output logic [SZ_W-1:0] ab_rs,
  output logic [SZ_W-1:0] ab_ws,
  output logic            err,
  output st_e             st
);
  logic [TS_W-1:0] now, mark, req_ts, tstall;
  logic            pend;

  logic [TS_W-1:0] span, amt_n;
  logic            single, legal, add_n, move, req_hit, conf_hit, lat;
  st_e             st_n;
  cat_e            cat_n;

  always_comb begin
    span     = now - mark;
    single   = (ev != '0) && ((ev & (ev - 1'b1)) == '0);
    legal    = 1'b0;
    add_n    = 1'b0;
    move     = 1'b0;
    req_hit  = 1'b0;
    conf_hit = 1'b0;
    lat      = 1'b0;
    st_n     = st;
    cat_n    = CAT_STALL;
    amt_n    = '0;
    if (single) begin
      case (st)
        S_IDLE: begin
          if (ev[EV_BEGIN] || ev[EV_BARIN]) begin
            legal = 1'b1; add_n = 1'b1; move = 1'b1;
            cat_n = CAT_NONTX; amt_n = span;
            st_n  = ev[EV_BEGIN] ? S_TXN : S_BARRIER;
          end
        end
        S_BARRIER: begin
          if (ev[EV_BAROUT]) begin
            legal = 1'b1; add_n = 1'b1; move = 1'b1;
            cat_n = CAT_BARRIER; amt_n = span; st_n = S_IDLE;
          end
        end
        S_TXN: begin
          if (ev[EV_REQ]) begin
            legal = 1'b1; req_hit = 1'b1;
          end else if (ev[EV_CONF] && pend) begin
            legal = 1'b1; conf_hit = 1'b1; add_n = 1'b1;
            cat_n = CAT_STALL; amt_n = now - req_ts;
          end else if (ev[EV_ABST]) begin
            legal = 1'b1; add_n = 1'b1; move = 1'b1;
            cat_n = CAT_WASTED; amt_n = span - tstall; st_n = S_ABORT;
          end else if (ev[EV_CMST] || ev[EV_CMDN]) begin
            legal = 1'b1; add_n = 1'b1; move = 1'b1;
            cat_n = CAT_USEFUL; amt_n = span - tstall;
            st_n  = ev[EV_CMST] ? S_COMMIT : S_IDLE;
          end
        end
        S_ABORT: begin
          if (ev[EV_ABDN]) begin
            legal = 1'b1; add_n = 1'b1; move = 1'b1; lat = 1'b1;
            cat_n = CAT_ABORT; amt_n = span; st_n = S_BACKOFF;
          end
        end
        S_BACKOFF: begin
          if (ev[EV_RETRY]) begin
            legal = 1'b1; add_n = 1'b1; move = 1'b1;
            cat_n = CAT_BACKOFF; amt_n = span; st_n = S_TXN;
          end
        end
        S_COMMIT: begin
          if (ev[EV_CMDN]) begin
            legal = 1'b1; add_n = 1'b1; move = 1'b1;
            cat_n = CAT_COMMIT; amt_n = span; st_n = S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0; mark <= '0; req_ts <= '0; tstall <= '0; pend <= 1'b0;
      st <= S_IDLE; err <= 1'b0; add_vld <= 1'b0; add_cat <= CAT_STALL;
      add_amt <= '0; ab_rs <= '0; ab_ws <= '0;
    end else begin
      now     <= now + 1'b1;
      add_vld <= 1'b0;
      if (clr) begin
        st <= S_IDLE; mark <= now + 1'b1; err <= 1'b0; pend <= 1'b0;
        tstall <= '0; ab_rs <= '0; ab_ws <= '0;
      end else begin
        if (ev != '0 && !legal) err <= 1'b1;
        if (legal) begin
          st      <= st_n;
          add_vld <= add_n;
          add_cat <= cat_n;
          add_amt <= amt_n;
          if (move) mark <= now;
          if (st_n == S_TXN && st != S_TXN) begin
            pend <= 1'b0; tstall <= '0;
          end
          if (req_hit) begin pend <= 1'b1; req_ts <= now; end
          if (conf_hit) begin pend <= 1'b0; tstall <= tstall + amt_n; end
          if (lat) begin ab_rs <= rs_size; ab_ws <= ws_size; end
        end
      end
    end
  end
endmodule

// File: rtl/txprof_accum.sv
module txprof_accum
  import txprof_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int TS_W  = 32,
  parameter int SZ_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             add_vld,
  input  cat_e             add_cat,
  input  logic [TS_W-1:0]  add_amt,
  input  logic [SZ_W-1:0]  ab_rs,
  input  logic [SZ_W-1:0]  ab_ws,
  input  logic             err,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  localparam int SUM_W = ((CNT_W > TS_W) ? CNT_W : TS_W) + 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt [NCAT];
  logic [CNT_W-1:0] total;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [TS_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b);
    return (s > SUM_W'(CMAX)) ? CMAX : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NCAT; i++) cnt[i] <= '0;
      total <= '0;
    end else begin
      for (int i = 0; i < NCAT; i++)
        if (add_vld && add_cat == cat_e'(i)) cnt[i] <= sat_add(cnt[i], add_amt);
      if (total != CMAX) total <= total + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      if (rd_addr == A_TOTAL) rd_data <= total;
      else if (rd_addr <= AW'(NCAT)) rd_data <= cnt[CW'(rd_addr - 1'b1)];
      else if (rd_addr == A_RSZ) rd_data <= CNT_W'(ab_rs);
      else if (rd_addr == A_WSZ) rd_data <= CNT_W'(ab_ws);
      else if (rd_addr == A_ERR) rd_data <= CNT_W'(err);
    end
  end
endmodule

// File: rtl/txprof_top.sv
module txprof_top
  import txprof_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int TS_W  = 32,
  parameter int SZ_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_begin,
  input  logic             ev_req,
  input  logic             ev_conflict,
  input  logic             ev_abort_start,
  input  logic             ev_abort_done,
  input  logic             ev_retry,
  input  logic             ev_commit_start,
  input  logic             ev_commit_done,
  input  logic             ev_bar_enter,
  input  logic             ev_bar_exit,
  input  logic [SZ_W-1:0]  rs_size,
  input  logic [SZ_W-1:0]  ws_size,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic             wr_data,
  input  logic             rd_en,
  input  logic [3:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             err
);
  logic [NEV-1:0]  ev;
  logic            clr;
  logic            add_vld;
  cat_e            add_cat;
  logic [TS_W-1:0] add_amt;
  logic [SZ_W-1:0] ab_rs, ab_ws;
  st_e             st;

  assign ev  = {ev_bar_exit, ev_bar_enter, ev_commit_done, ev_commit_start,
                ev_retry, ev_abort_done, ev_abort_start, ev_conflict,
                ev_req, ev_begin};
  assign clr = wr_en && (wr_addr == A_CLR) && wr_data;

  txprof_fsm #(.TS_W(TS_W), .SZ_W(SZ_W)) u_fsm (
    .clk(clk), .rst(rst), .clr(clr), .ev(ev),
    .rs_size(rs_size), .ws_size(ws_size),
    .add_vld(add_vld), .add_cat(add_cat), .add_amt(add_amt),
    .ab_rs(ab_rs), .ab_ws(ab_ws), .err(err), .st(st)
  );

  txprof_accum #(.CNT_W(CNT_W), .TS_W(TS_W), .SZ_W(SZ_W)) u_acc (
    .clk(clk), .rst(rst), .clr(clr),
    .add_vld(add_vld), .add_cat(add_cat), .add_amt(add_amt),
    .ab_rs(ab_rs), .ab_ws(ab_ws), .err(err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/txprof_chk.sv
module txprof_chk
  import txprof_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           clr,
  input logic [NEV-1:0] ev,
  input st_e            st,
  input logic           add_vld,
  input cat_e           add_cat,
  input logic           err
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err); // R9

  AST_ORPHAN_ABORT_DONE: assert property (@(posedge clk) disable iff (rst)
    (ev == (NEV'(1) << EV_ABDN) && st != S_ABORT && !clr) |=> (err && !add_vld)); // R9

  AST_MULTI_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ($countones(ev) > 1) |=> !add_vld); // R10

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!add_vld && !err && st == S_IDLE)); // R12

  AST_RETRY_BACKOFF: assert property (@(posedge clk) disable iff (rst)
    (st == S_BACKOFF && ev == (NEV'(1) << EV_RETRY) && !clr)
      |=> (add_vld && add_cat == CAT_BACKOFF && st == S_TXN)); // R4
endmodule

bind txprof_top txprof_chk u_chk (
  .clk(clk), .rst(rst), .clr(clr), .ev(ev), .st(st),
  .add_vld(add_vld), .add_cat(add_cat), .err(err)
);

// File: tb/txprof_top_bench.sv
module txprof_top_bench;
  localparam int CNT_W = 12;
  localparam int TS_W  = 16;
  localparam int SZ_W  = 8;
  localparam int CMAXI = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] evv = '0;
  logic [SZ_W-1:0] rs_size = '0, ws_size = '0;
  logic wr_en = 1'b0, wr_data = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic err;

  int cyc = 0;
  int checks = 0, fails = 0;
  logic rd_seen = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_seen <= rd_en;
  end

  txprof_top #(.CNT_W(CNT_W), .TS_W(TS_W), .SZ_W(SZ_W)) u_txprof_top (
    .clk(clk), .rst(rst),
    .ev_begin(evv[0]), .ev_req(evv[1]), .ev_conflict(evv[2]),
    .ev_abort_start(evv[3]), .ev_abort_done(evv[4]), .ev_retry(evv[5]),
    .ev_commit_start(evv[6]), .ev_commit_done(evv[7]),
    .ev_bar_enter(evv[8]), .ev_bar_exit(evv[9]),
    .rs_size(rs_size), .ws_size(ws_size),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .err(err)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) chk(tag_q.pop_front(), int'(rd_data), exp_q.pop_front());
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int i, output int at);
    @(negedge clk); evv = 10'(1) << i;
    @(negedge clk); evv = '0; at = cyc;
  endtask

  task automatic rd(input int addr, input int expv, input string tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = 4'(addr);
    exp_q.push_back(expv); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_clear(output int c0);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'd15; wr_data = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = 1'b0; c0 = cyc;
  endtask

  int stall, aborts, wasted, useful, commit, nontx, backoff, barrier;

  initial begin
    int c0, b, r, c, s, d, e, x, b2, r2, c2, a, ad, rt, d2, tmp, b3, d3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    chk("R12 err after reset", int'(err), 0);
    rd(1, 0, "R12 stall after reset");
    rd(11, 0, "R12 err reg after reset");

    do_clear(c0);
    idle(3);
    pulse(0, b);  nontx = b - (c0 + 1);
    idle(2);
    pulse(1, r);  idle(4);
    pulse(2, c);  stall = c - r;
    idle(3);
    pulse(6, s);  useful = s - b - stall;
    idle(2);
    pulse(7, d);  commit = d - s;
    idle(2);
    rd(1, stall, "R2 stall");
    rd(4, useful, "R5 useful");
    rd(5, commit, "R5 commit");
    rd(6, nontx, "R7 nontx first");

    pulse(8, e);  nontx += e - d;
    idle(5);
    pulse(9, x);  barrier = x - e;
    idle(1);
    pulse(0, b2); nontx += b2 - x;
    idle(1);
    pulse(1, r2); idle(2);
    pulse(2, c2); stall += c2 - r2;
    idle(3);
    pulse(3, a);  wasted = a - b2 - (c2 - r2);
    rs_size = 8'd37; ws_size = 8'd5;
    idle(4);
    pulse(4, ad); aborts = ad - a;
    rs_size = 8'd99; ws_size = 8'd98;
    idle(6);
    pulse(5, rt); backoff = rt - ad;
    idle(3);
    pulse(7, d2); useful += d2 - rt;
    idle(2);
    rd(3, wasted, "R3 wasted excludes stall");
    rd(2, aborts, "R3 abort");
    rd(7, backoff, "R4 backoff");
    rd(4, useful, "R6 useful direct commit");
    rd(5, commit, "R6 commit unchanged");
    rd(8, barrier, "R7 barrier");
    rd(6, nontx, "R7 nontx total");
    rd(9, 37, "R8 read-set size");
    rd(10, 5, "R8 write-set size");
    @(negedge clk); rd_en = 1'b1; rd_addr = 4'd0;
    tmp = stall + aborts + wasted + useful + commit + nontx + backoff + barrier;
    exp_q.push_back(tmp + (cyc + 1 - d2)); tag_q.push_back("R1 partition identity");
    @(negedge clk); rd_en = 1'b0;

    pulse(4, tmp);
    idle(1);
    chk("R9 err pin after orphan", int'(err), 1);
    idle(1);
    rd(2, aborts, "R9 abort counter untouched");
    rd(11, 1, "R9 err register");
    idle(3);
    chk("R9 err sticky", int'(err), 1);

    do_clear(c0);
    idle(1);
    chk("R12 err cleared", int'(err), 0);
    rd(1, 0, "R12 stall cleared");
    rd(9, 0, "R12 size cleared");

    @(negedge clk); evv = 10'b1_0000_0001;
    @(negedge clk); evv = '0;
    idle(1);
    chk("R10 err after double pulse", int'(err), 1);
    idle(2);
    pulse(0, b3);
    idle(2);
    rd(6, b3 - (c0 + 1), "R10 double pulse ignored");
    pulse(7, d3);
    idle(2);
    rd(4, d3 - b3, "R6 useful single direct commit");

    do_clear(c0);
    idle(CMAXI + 100);
    rd(0, CMAXI, "R11 total saturates");
    pulse(0, tmp);
    idle(2);
    rd(6, CMAXI, "R11 nontx saturates");
    idle(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule